// File: doc/BRIEF.md
# Greedy Memory Bank Size Allocator

This unit splits a total installed memory size, given in MiB, across a small set of memory banks. Each bank may only take one of a fixed list of allowed sizes. The list is a parameter array that runs from the largest size to the smallest and ends in a zero entry. A one-cycle start pulse launches an allocation. The unit then visits the banks in order. For each bank it scans the size list from the top and gives the bank the first size that still fits in the memory left over. That bank's base address is the running sum of all earlier assignments.

The walk stops as soon as the leftover reaches zero. It also stops after the last bank. At that point the unit raises a one-cycle done pulse and leaves the per-bank base and size values on its outputs. If memory is still left over, an error flag is set, and a suggested valid total is reported next to it. Software or a boot sequencer reads these values and then programs the real bank registers, which sit outside this unit.

The unit has no streaming data, so every pin is a plain control or status signal. There is no back-pressure: start is taken on any clock edge where the unit is idle and is ignored while it is busy. Results stay stable until the next accepted start.

Top module: `bank_split_alloc`

## Requirements
- R1: After reset, busy, done and alloc_err are low, and suggest_mib and every bank base and size are zero.
- R2: A start pulse seen while idle makes busy high from the next cycle on and clears all bank outputs, alloc_err and suggest_mib. A start seen while busy has no effect on the results or on the timing.
- R3: Banks are handled in index order. Each bank gets the first list entry, counted from index 0 (the largest), that is non-zero and not larger than the leftover size. Its base is the sum of the sizes given to lower banks, and the leftover then drops by the size given.
- R4: Each busy cycle examines exactly one list entry. A bank is finished in the cycle that assigns it, or in the cycle that reaches the zero terminator or the last list slot without a fit. The next bank starts again at list index 0.
- R5: When the leftover becomes zero, the allocation ends in that same cycle. All later banks keep size 0 and base 0.
- R6: A bank for which no entry fits gets size 0 and base 0, and the leftover passes on unchanged to the next bank.
- R7: alloc_err is high at done exactly when a non-zero leftover remains after the last bank.
- R8: At done, suggest_mib holds the total amount allocated. If nothing was allocated, it holds the smallest non-zero list entry instead.
- R9: done is a one-cycle pulse in the first cycle with busy low after an allocation. All results hold unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an allocation; taken only while idle |
| total_mib | input | SIZE_W | Total memory to split, in MiB, sampled with start |
| busy | output | 1 | High while the allocation walk runs |
| done | output | 1 | One-cycle pulse when results are ready |
| alloc_err | output | 1 | Memory left over that no bank could take |
| suggest_mib | output | SIZE_W | Suggested valid total, in MiB |
| bank_base_mib | output | NUM_BANKS*SIZE_W | Per-bank base, bank i in bits [i*SIZE_W +: SIZE_W] |
| bank_size_mib | output | NUM_BANKS*SIZE_W | Per-bank size, bank i in bits [i*SIZE_W +: SIZE_W]; 0 means no assignment |

## Verification
The bench targets several corner cases, and each one catches a specific kind of bug:

- **Exact fit after the first bank.** A total that fits exactly checks the early stop. A design that ignores it keeps walking and takes extra cycles.
- **Total smaller than every entry.** This checks the terminator handling. A design that mishandles it either hangs or writes a zero-size bank with a non-zero base.
- **Zero total.** This checks the empty-allocation fallback for the suggested size.
- **Oversized total.** This checks that the error flag is raised and that the suggestion equals the allocated amount rather than the request.
- **Restart attempt mid-walk.** A start pulse in the middle of a walk must not corrupt results. A design that restarts would show a shifted latency and different sizes.

The busy and done pins are compared against the cycle count predicted on every clock, so an off-by-one in the per-entry scan shows up directly.

// File: rtl/bank_alloc_pkg.sv
package bank_alloc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } alloc_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/alloc_size_table.sv
module alloc_size_table
  import bank_alloc_pkg::*;
#(
  parameter int unsigned TBL_DEPTH = 8,
  parameter int unsigned SIZE_W    = 16,
  parameter logic [TBL_DEPTH-1:0][SIZE_W-1:0] SIZE_TABLE = '0,
  localparam int unsigned IW = idx_width(TBL_DEPTH)
) (
  input  logic [IW-1:0]     idx,
  output logic [SIZE_W-1:0] entry,
  output logic [SIZE_W-1:0] smallest,
  output logic              row_end
);

  logic [SIZE_W-1:0] ent [TBL_DEPTH];

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_ent
    assign ent[g] = SIZE_TABLE[g];
  end

  assign entry   = ent[idx];
  assign row_end = (entry == '0) || (idx == IW'(TBL_DEPTH - 1));

  // smallest non-zero entry before the terminator
  logic hit_zero;
  always_comb begin
    smallest = '0;
    hit_zero = 1'b0;
    for (int i = 0; i < TBL_DEPTH; i++) begin
      if (!hit_zero) begin
        if (ent[i] == '0) hit_zero = 1'b1;
        else              smallest = ent[i];
      end
    end
  end

endmodule

// File: rtl/alloc_walker.sv
module alloc_walker
  import bank_alloc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned TBL_DEPTH = 8,
  parameter int unsigned SIZE_W    = 16,
  localparam int unsigned IW = idx_width(TBL_DEPTH),
  localparam int unsigned BW = idx_width(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] total_mib,
  input  logic [SIZE_W-1:0] entry,
  input  logic [SIZE_W-1:0] smallest,
  input  logic              row_end,
  output logic [IW-1:0]     idx,
  output logic [BW-1:0]     bank_sel,
  output logic              assign_en,
  output logic [SIZE_W-1:0] assign_base,
  output logic              clear_all,
  output logic              busy,
  output logic              done,
  output logic              alloc_err,
  output logic [SIZE_W-1:0] suggest_mib
);

  alloc_state_e      state;
  logic [SIZE_W-1:0] remain;
  logic [SIZE_W-1:0] base_acc;

  logic              fits;
  logic              last_bank;
  logic [SIZE_W-1:0] remain_nxt;
  logic [SIZE_W-1:0] base_nxt;
  logic              finish;

  assign busy      = (state == ST_SCAN);
  assign fits      = busy && (entry != '0) && (entry <= remain);
  assign last_bank = (bank_sel == BW'(NUM_BANKS - 1));
  assign remain_nxt = fits ? (remain - entry) : remain;
  assign base_nxt   = fits ? (base_acc + entry) : base_acc;
  assign finish     = busy && ((fits && (remain_nxt == '0)) ||
                               ((fits || row_end) && last_bank));

  assign assign_en   = fits;
  assign assign_base = base_acc;
  assign clear_all   = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      remain      <= '0;
      base_acc    <= '0;
      bank_sel    <= '0;
      idx         <= '0;
      done        <= 1'b0;
      alloc_err   <= 1'b0;
      suggest_mib <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state       <= ST_SCAN;
            remain      <= total_mib;
            base_acc    <= '0;
            bank_sel    <= '0;
            idx         <= '0;
            alloc_err   <= 1'b0;
            suggest_mib <= '0;
          end
        end
        ST_SCAN: begin
          remain   <= remain_nxt;
          base_acc <= base_nxt;
          if (finish) begin
            state       <= ST_IDLE;
            done        <= 1'b1;
            alloc_err   <= (remain_nxt != '0);
            suggest_mib <= (base_nxt != '0) ? base_nxt : smallest;
            idx         <= '0;
          end else if (fits || row_end) begin
            bank_sel <= bank_sel + 1'b1;
            idx      <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/alloc_bank_regs.sv
module alloc_bank_regs
  import bank_alloc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned SIZE_W    = 16,
  localparam int unsigned BW = idx_width(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_all,
  input  logic                        assign_en,
  input  logic [BW-1:0]               bank_sel,
  input  logic [SIZE_W-1:0]           assign_base,
  input  logic [SIZE_W-1:0]           assign_size,
  output logic [NUM_BANKS*SIZE_W-1:0] bank_base_mib,
  output logic [NUM_BANKS*SIZE_W-1:0] bank_size_mib
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SIZE_W-1:0] base_q;
    logic [SIZE_W-1:0] size_q;

    always_ff @(posedge clk) begin
      if (!rst_n || clear_all) begin
        base_q <= '0;
        size_q <= '0;
      end else if (assign_en && (bank_sel == BW'(b))) begin
        base_q <= assign_base;
        size_q <= assign_size;
      end
    end

    assign bank_base_mib[b*SIZE_W +: SIZE_W] = base_q;
    assign bank_size_mib[b*SIZE_W +: SIZE_W] = size_q;
  end

endmodule

// File: rtl/bank_split_alloc.sv
module bank_split_alloc
  import bank_alloc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned TBL_DEPTH = 8,
  parameter int unsigned SIZE_W    = 16,
  parameter logic [TBL_DEPTH-1:0][SIZE_W-1:0] SIZE_TABLE = {
    16'd0, 16'd4, 16'd8, 16'd16, 16'd32, 16'd64, 16'd128, 16'd256
  }
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [SIZE_W-1:0]           total_mib,
  output logic                        busy,
  output logic                        done,
  output logic                        alloc_err,
  output logic [SIZE_W-1:0]           suggest_mib,
  output logic [NUM_BANKS*SIZE_W-1:0] bank_base_mib,
  output logic [NUM_BANKS*SIZE_W-1:0] bank_size_mib
);

  localparam int unsigned IW = idx_width(TBL_DEPTH);
  localparam int unsigned BW = idx_width(NUM_BANKS);

  logic [IW-1:0]     idx;
  logic [BW-1:0]     bank_sel;
  logic [SIZE_W-1:0] entry;
  logic [SIZE_W-1:0] smallest;
  logic              row_end;
  logic              assign_en;
  logic [SIZE_W-1:0] assign_base;
  logic              clear_all;

  alloc_size_table #(
    .TBL_DEPTH (TBL_DEPTH),
    .SIZE_W    (SIZE_W),
    .SIZE_TABLE(SIZE_TABLE)
  ) u_table (
    .idx      (idx),
    .entry    (entry),
    .smallest (smallest),
    .row_end  (row_end)
  );

  alloc_walker #(
    .NUM_BANKS(NUM_BANKS),
    .TBL_DEPTH(TBL_DEPTH),
    .SIZE_W   (SIZE_W)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .total_mib   (total_mib),
    .entry       (entry),
    .smallest    (smallest),
    .row_end     (row_end),
    .idx         (idx),
    .bank_sel    (bank_sel),
    .assign_en   (assign_en),
    .assign_base (assign_base),
    .clear_all   (clear_all),
    .busy        (busy),
    .done        (done),
    .alloc_err   (alloc_err),
    .suggest_mib (suggest_mib)
  );

  alloc_bank_regs #(
    .NUM_BANKS(NUM_BANKS),
    .SIZE_W   (SIZE_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_all     (clear_all),
    .assign_en     (assign_en),
    .bank_sel      (bank_sel),
    .assign_base   (assign_base),
    .assign_size   (entry),
    .bank_base_mib (bank_base_mib),
    .bank_size_mib (bank_size_mib)
  );

endmodule

// File: rtl/bank_split_alloc_chk.sv
module bank_split_alloc_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned SIZE_W    = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic                        busy,
  input logic                        done,
  input logic                        alloc_err,
  input logic [SIZE_W-1:0]           suggest_mib,
  input logic [NUM_BANKS*SIZE_W-1:0] bank_base_mib,
  input logic [NUM_BANKS*SIZE_W-1:0] bank_size_mib
);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r2_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(bank_size_mib) && $stable(bank_base_mib) &&
                           $stable(alloc_err) && $stable(suggest_mib)));

  a_r7_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_err) |-> done);

  a_r8_suggest_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (suggest_mib != '0));

endmodule

bind bank_split_alloc bank_split_alloc_chk #(
  .NUM_BANKS(NUM_BANKS),
  .SIZE_W   (SIZE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .alloc_err     (alloc_err),
  .suggest_mib   (suggest_mib),
  .bank_base_mib (bank_base_mib),
  .bank_size_mib (bank_size_mib)
);

// File: tb/bank_split_alloc_tb.sv
`timescale 1ns/1ps
module bank_split_alloc_tb;

  localparam int NB = 4;
  localparam int TD = 8;
  localparam int SW = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [SW-1:0]    total_mib = '0;
  logic             busy, done, alloc_err;
  logic [SW-1:0]    suggest_mib;
  logic [NB*SW-1:0] bank_base_mib, bank_size_mib;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int tbl [TD] = '{256, 128, 64, 32, 16, 8, 4, 0};

  int exp_base [NB];
  int exp_size [NB];
  int exp_err;
  int exp_sug;
  int exp_lat;

  always #10 clk = ~clk;

  bank_split_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_mib(total_mib),
    .busy(busy), .done(done), .alloc_err(alloc_err), .suggest_mib(suggest_mib),
    .bank_base_mib(bank_base_mib), .bank_size_mib(bank_size_mib)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: greedy split and its cycle count
  task automatic model(input int total);
    int rem, base, smallest;
    bit stop;
    rem = total; base = 0; exp_lat = 0; stop = 0; smallest = 0;
    for (int i = 0; i < TD; i++) if (tbl[i] != 0) smallest = tbl[i]; else break;
    for (int b = 0; b < NB; b++) begin
      exp_base[b] = 0; exp_size[b] = 0;
    end
    for (int b = 0; b < NB && !stop; b++) begin
      for (int j = 0; j < TD; j++) begin
        exp_lat++;
        if (tbl[j] != 0 && tbl[j] <= rem) begin
          exp_base[b] = base; exp_size[b] = tbl[j];
          base += tbl[j]; rem -= tbl[j];
          if (rem == 0) stop = 1;
          break;
        end
        if (tbl[j] == 0) break;
      end
    end
    exp_err = (rem != 0);
    exp_sug = (base != 0) ? base : smallest;
  endtask

  task automatic check_results(input string tag);
    for (int b = 0; b < NB; b++) begin
      chk(bank_size_mib[b*SW +: SW] == exp_size[b], {tag, " R3 bank size"},
          bank_size_mib[b*SW +: SW], exp_size[b]);
      chk(bank_base_mib[b*SW +: SW] == exp_base[b], {tag, " R3 bank base"},
          bank_base_mib[b*SW +: SW], exp_base[b]);
    end
    chk(alloc_err == exp_err, {tag, " R7 error flag"}, alloc_err, exp_err);
    chk(suggest_mib == exp_sug, {tag, " R8 suggestion"}, suggest_mib, exp_sug);
  endtask

  // run one allocation, comparing busy/done every clock
  task automatic run(input int total, input bit poke, input string tag);
    model(total);
    @(negedge clk);
    total_mib = SW'(total);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
    chk(done == 1'b0, {tag, " R9 no done yet"}, done, 0);
    for (int c = 1; c <= exp_lat; c++) begin
      if (poke && c == 1) begin
        total_mib = SW'(total + 37);
        start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(busy == (c < exp_lat), {tag, " R4 busy per cycle"}, busy, c < exp_lat);
      chk(done == (c == exp_lat), {tag, " R4 done timing"}, done, c == exp_lat);
    end
    check_results(tag);
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R9 done single pulse"}, done, 0);
    end
    check_results({tag, " R9 hold"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && alloc_err == 0, "R1 control low", {busy, done, alloc_err}, 0);
    chk(suggest_mib == 0, "R1 suggestion zero", suggest_mib, 0);
    chk(bank_size_mib == 0 && bank_base_mib == 0, "R1 banks zero", bank_size_mib, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(512,  0, "exact two banks R5");
    run(100,  0, "mixed sizes R3");
    run(1100, 0, "oversize R7");
    run(2,    0, "no fit R6");
    run(0,    0, "zero total R8");
    run(6,    0, "partial R6");
    run(300,  0, "four banks R3");
    run(100,  1, "start ignored while busy R2");
    run(1024, 0, "full four banks R5");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule